// File: doc/BRIEF.md
# NAND Prefetch Engine Control and Status

This block keeps the software-visible state of a prefetch and write-posting engine in an external memory controller. It holds a configuration word, a transfer count, a start flag, a FIFO fill pointer and a remaining-transfer count. Software reads and writes these through a single-cycle 32-bit register port. A read-only status word packs the pointer, a FIFO threshold flag and the remaining count.

The data path is not part of the block. Two strobes stand in for it. `fifo_push` marks a word entering the FIFO in read (prefetch) mode. `fifo_pop` marks a word leaving it in write-posting mode. Starting the engine preloads the pointer: to full (the FIFO depth, 64 by default) for write-posting, and to empty for prefetch. The count is loaded from the transfer count. Each accepted strobe moves the pointer by one and uses up one transfer. When the last transfer is used up, the start flag clears by itself.

Top module: `prefetch_ctl`

## Requirements
- R1: After reset, the configuration reads 0x00004000, and the transfer count, the control register and the status word all read 0.
- R2: The configuration register is at address 0. A write keeps only the bits in mask 0x7F8F7FBF. Bit 0 selects write-posting (1) or prefetch (0). Bits 14:8 hold the 7-bit FIFO threshold.
- R3: The transfer count register is at address 1. A write keeps bits 13:0 (mask 0x3FFF) and reads them back zero-extended.
- R4: The control register is at address 2. Writing bit 0 as 1 starts the engine and writing it as 0 stops it. A read returns the start flag in bit 0, with all other bits 0.
- R5: A start loads the remaining count from the transfer count. It loads the pointer with the FIFO depth (64) in write-posting mode and with 0 in prefetch mode.
- R6: The status word is at address 3. It has the pointer in bits 31:24, the threshold flag in bit 16 and the remaining count in bits 13:0. All other bits read 0.
- R7: The threshold flag is 1 exactly when the pointer is greater than or equal to configuration bits 14:8.
- R8: Writes to the status word or to an unmapped address change nothing. Unmapped addresses read 0.
- R9: In prefetch mode a push raises the pointer by one. A push with the pointer at 64 is ignored, and pops are ignored.
- R10: In write-posting mode a pop lowers the pointer by one. A pop with the pointer at 0 is ignored, and pushes are ignored.
- R11: While the start flag is clear, strobes change neither the pointer nor the remaining count.
- R12: Each accepted strobe lowers the remaining count by one. The strobe that brings it to 0 also clears the start flag.
- R13: A start with a transfer count of 0 still preloads the pointer and count, but leaves the start flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after the address |
| fifo_push | input | 1 | A word entered the FIFO (prefetch mode) |
| fifo_pop | input | 1 | A word left the FIFO (write-posting mode) |

## Verification
The bench builds the block with its default parameters: a FIFO depth of 64, a 14-bit transfer count and a 4-bit address. With these values it can walk the pointer through every value from empty to full and past saturation, in both directions. It also sweeps all 128 threshold settings against a full FIFO, so every flag boundary is reached. Short transfers show the self-clearing stop, the zero-count start and the freeze after a software stop.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam int unsigned REG_W = 32;

  // word offsets of the register port
  localparam int unsigned OFF_CFG  = 0;
  localparam int unsigned OFF_XFER = 1;
  localparam int unsigned OFF_CTRL = 2;
  localparam int unsigned OFF_STAT = 3;

  localparam logic [REG_W-1:0] CFG_KEEP  = 32'h7F8F_7FBF;
  localparam logic [REG_W-1:0] CFG_RESET = 32'h0000_4000;

  localparam int unsigned DIR_BIT  = 0;
  localparam int unsigned THR_LSB  = 8;
  localparam int unsigned THR_W    = 7;

  localparam int unsigned STAT_PTR_LSB = 24;
  localparam int unsigned STAT_PTR_W   = 8;
  localparam int unsigned STAT_FLAG    = 16;

  typedef struct packed {
    logic cfg;
    logic xfer;
    logic ctrl;
  } wr_sel_t;
endpackage

// File: rtl/pfe_regfile.sv
module pfe_regfile
  import pfe_pkg::*;
#(
  parameter int unsigned XFER_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_sel_t           wsel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  cfg_q,
  output logic [XFER_W-1:0] xfer_q
);
  logic [REG_W-1:0] cfg_d;

  always_comb cfg_d = wdata & CFG_KEEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      xfer_q <= '0;
    end else begin
      if (wsel.cfg)  cfg_q  <= cfg_d;
      if (wsel.xfer) xfer_q <= wdata[XFER_W-1:0];
    end
  end
endmodule

// File: rtl/pfe_engine.sv
module pfe_engine #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned XFER_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              ctrl_bit,
  input  logic              dir_wp,
  input  logic [XFER_W-1:0] xfer_q,
  input  logic              push,
  input  logic              pop,
  output logic              run_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [XFER_W-1:0] cnt_q
);
  localparam logic [PTR_W-1:0]  PTR_FULL = PTR_W'(DEPTH);
  localparam logic [XFER_W-1:0] CNT_ONE  = XFER_W'(1);

  logic fill_ok;
  logic drain_ok;
  logic step;
  logic last;

  always_comb begin
    fill_ok  = !dir_wp && push && (ptr_q != PTR_FULL);
    drain_ok =  dir_wp && pop  && (ptr_q != '0);
    step     = run_q && (fill_ok || drain_ok);
    last     = (cnt_q == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (ctrl_we) begin
      run_q <= ctrl_bit && (xfer_q != '0);
      if (ctrl_bit) begin
        ptr_q <= dir_wp ? PTR_FULL : '0;
        cnt_q <= xfer_q;
      end
    end else if (step) begin
      ptr_q <= fill_ok ? ptr_q + 1'b1 : ptr_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
      if (last) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pfe_status.sv
module pfe_status
  import pfe_pkg::*;
#(
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned XFER_W = 14
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [XFER_W-1:0] cnt,
  input  logic [THR_W-1:0]  thr,
  output logic [REG_W-1:0]  stat
);
  localparam int unsigned CMP_W = ((PTR_W > THR_W) ? PTR_W : THR_W) + 1;

  logic at_thr;

  always_comb begin
    at_thr = (CMP_W'(ptr) >= CMP_W'(thr));
    stat   = '0;
    stat[STAT_PTR_LSB +: STAT_PTR_W] = STAT_PTR_W'(ptr);
    stat[STAT_FLAG]                  = at_thr;
    stat[XFER_W-1:0]                 = cnt;
  end
endmodule

// File: rtl/prefetch_ctl.sv
module prefetch_ctl
  import pfe_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned XFER_W = 14,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fifo_push,
  input  logic              fifo_pop
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  wr_sel_t           wsel;
  logic [REG_W-1:0]  cfg_q;
  logic [XFER_W-1:0] xfer_q;
  logic              eng_run;
  logic [PTR_W-1:0]  eng_ptr;
  logic [XFER_W-1:0] eng_cnt;
  logic [REG_W-1:0]  stat_word;
  logic [REG_W-1:0]  rd_mux;

  always_comb begin
    wsel.cfg  = reg_we && (reg_addr == ADDR_W'(OFF_CFG));
    wsel.xfer = reg_we && (reg_addr == ADDR_W'(OFF_XFER));
    wsel.ctrl = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
  end

  pfe_regfile #(.XFER_W(XFER_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wsel   (wsel),
    .wdata  (reg_wdata),
    .cfg_q  (cfg_q),
    .xfer_q (xfer_q)
  );

  pfe_engine #(.DEPTH(DEPTH), .PTR_W(PTR_W), .XFER_W(XFER_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (wsel.ctrl),
    .ctrl_bit (reg_wdata[0]),
    .dir_wp   (cfg_q[DIR_BIT]),
    .xfer_q   (xfer_q),
    .push     (fifo_push),
    .pop      (fifo_pop),
    .run_q    (eng_run),
    .ptr_q    (eng_ptr),
    .cnt_q    (eng_cnt)
  );

  pfe_status #(.PTR_W(PTR_W), .XFER_W(XFER_W)) u_stat (
    .ptr  (eng_ptr),
    .cnt  (eng_cnt),
    .thr  (cfg_q[THR_LSB +: THR_W]),
    .stat (stat_word)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFF_CFG))       rd_mux = cfg_q;
    else if (reg_addr == ADDR_W'(OFF_XFER)) rd_mux = REG_W'(xfer_q);
    else if (reg_addr == ADDR_W'(OFF_CTRL)) rd_mux = REG_W'(eng_run);
    else if (reg_addr == ADDR_W'(OFF_STAT)) rd_mux = stat_word;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pfe_chk.sv
module pfe_chk
  import pfe_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned XFER_W = 14,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              wbit0,
  input logic [31:0]       reg_rdata,
  input logic              dir_wp,
  input logic              run_q,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [XFER_W-1:0] cnt_q
);
  localparam logic [31:0] LOW_RSVD = ((32'h1 << 16) - 1) & ~((32'h1 << XFER_W) - 1);
  localparam logic [31:0] RSVD     = 32'h00FE_0000 | LOW_RSVD;

  logic ctrl_wr;
  always_comb ctrl_wr = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_W'(DEPTH));

  assert_run_has_count_R12: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

  assert_preload_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wbit0) |=> (ptr_q == ($past(dir_wp) ? PTR_W'(DEPTH) : '0)));

  assert_idle_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctrl_wr) |=> ($stable(ptr_q) && $stable(cnt_q)));

  assert_step_pair_R12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> ((ptr_q == $past(ptr_q)) == (cnt_q == $past(cnt_q))));

  assert_stat_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(OFF_STAT)) |=> ((reg_rdata & RSVD) == '0));
endmodule

bind prefetch_ctl pfe_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .XFER_W(XFER_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .wbit0     (reg_wdata[0]),
  .reg_rdata (reg_rdata),
  .dir_wp    (cfg_q[0]),
  .run_q     (eng_run),
  .ptr_q     (eng_ptr),
  .cnt_q     (eng_cnt)
);

// File: tb/test_prefetch_ctl.sv
module test_prefetch_ctl;
  localparam int CLK_PER = 10;
  localparam int DEPTH = 64;
  localparam logic [3:0] A_CFG = 4'd0, A_XFER = 4'd1, A_CTRL = 4'd2, A_STAT = 4'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fifo_push = 1'b0;
  logic        fifo_pop = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  // expected-state model built from the requirements
  int e_ptr = 0, e_cnt = 0, e_thr = 64, e_xfer = 0;
  bit e_run = 0, e_dir = 0;

  always #(CLK_PER/2) clk = ~clk;

  prefetch_ctl i_prefetch_ctl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_cfg(input bit dir, input int thr);
    e_dir = dir; e_thr = thr;
    wr(A_CFG, (32'(thr) << 8) | 32'(dir));
  endtask

  task automatic ctrl(input bit b);
    wr(A_CTRL, {31'h7FFF_FFFF, b});
    if (b) begin
      e_ptr = e_dir ? DEPTH : 0;
      e_cnt = e_xfer;
      e_run = (e_xfer != 0);
    end else e_run = 0;
  endtask

  task automatic strobe(input bit pu, input bit po);
    @(negedge clk);
    fifo_push = pu; fifo_pop = po;
    @(negedge clk);
    fifo_push = 1'b0; fifo_pop = 1'b0;
    if (e_run) begin
      if ((!e_dir && pu && e_ptr < DEPTH) || (e_dir && po && e_ptr > 0)) begin
        e_ptr = e_dir ? e_ptr - 1 : e_ptr + 1;
        e_cnt--;
        if (e_cnt == 0) e_run = 0;
      end
    end
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] v;
    logic [31:0] exp;
    rd(A_STAT, v);
    exp = (32'(e_ptr) << 24) | ((e_ptr >= e_thr) ? 32'h0001_0000 : 32'h0) | 32'(e_cnt);
    chk(tag, v, exp);
  endtask

  task automatic chk_run(input string tag);
    logic [31:0] v;
    rd(A_CTRL, v);
    chk(tag, v, 32'(e_run));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0000_4000);
    rd(A_XFER, v); chk("R1 xfer", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);
    rd(4'd9, v);   chk("R8 unmapped read", v, 32'h0);

    // R2 configuration mask
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v); chk("R2 all ones", v, 32'h7F8F_7FBF);
    wr(A_CFG, 32'h1234_5678); rd(A_CFG, v); chk("R2 pattern", v, 32'h1234_5678 & 32'h7F8F_7FBF);

    // R3 transfer count mask
    wr(A_XFER, 32'hFFFF_FFFF); rd(A_XFER, v); chk("R3 all ones", v, 32'h0000_3FFF);
    wr(A_XFER, 32'hABCD_1234); rd(A_XFER, v); chk("R3 pattern", v, 32'h0000_1234);

    // R8 writes to status and unmapped addresses
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); chk("R8 status write", v, 32'h0);
    wr(4'd12, 32'h0);
    rd(A_CFG, v);  chk("R8 unmapped write cfg", v, 32'h1234_5678 & 32'h7F8F_7FBF);
    rd(A_XFER, v); chk("R8 unmapped write xfer", v, 32'h0000_1234);

    // R4, R5 prefetch start
    set_cfg(0, 32); e_xfer = 100; wr(A_XFER, 100);
    ctrl(0); chk_run("R4 write zero");
    ctrl(1); chk_run("R4 start reads one");
    chk_stat("R5 prefetch preload");
    strobe(0, 1); chk_stat("R9 pop ignored in prefetch");
    // R9, R7, R6 pointer walk up past saturation
    for (int i = 0; i < 70; i++) begin
      strobe(1, 0);
      chk_stat("R9 R7 push walk");
    end
    // R7 full threshold sweep at pointer 64
    for (int t = 0; t < 128; t++) begin
      set_cfg(0, t);
      chk_stat("R7 threshold sweep");
    end

    // R10, R12 write-posting short transfer
    set_cfg(1, 16); e_xfer = 5; wr(A_XFER, 5);
    ctrl(1); chk_stat("R5 write-posting preload");
    strobe(1, 0); chk_stat("R10 push ignored in write-posting");
    for (int i = 0; i < 5; i++) begin
      strobe(0, 1);
      chk_stat("R10 R12 pop walk");
    end
    chk_run("R12 self stop");
    strobe(0, 1); chk_stat("R11 pop after stop");

    // R10 drain to empty and saturate
    e_xfer = 70; wr(A_XFER, 70);
    ctrl(1);
    for (int i = 0; i < 66; i++) begin
      strobe(0, 1);
      chk_stat("R10 drain walk");
    end
    chk_run("R12 still running with count left");

    // R13 zero-count start
    e_xfer = 0; wr(A_XFER, 0);
    ctrl(1); chk_run("R13 zero count run flag");
    chk_stat("R13 zero count preload");
    strobe(0, 1); chk_stat("R13 pop ignored");

    // R11 software stop freezes state
    e_xfer = 10; wr(A_XFER, 10);
    ctrl(1); strobe(0, 1); strobe(0, 1);
    chk_stat("R11 before stop");
    ctrl(0); chk_run("R4 stop");
    for (int i = 0; i < 3; i++) strobe(0, 1);
    chk_stat("R11 frozen after stop");

    // R5 restart in prefetch mode
    set_cfg(0, 1); ctrl(1); chk_stat("R5 restart prefetch");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule